// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every cycle on a processor system bus. It raises a break interrupt request when a cycle meets the conditions software has programmed. It holds two comparison channels. Each channel has a target address with a per-bit don't-care mask and a bus-cycle qualifier. The qualifier selects the bus master, the access kind, the direction and, optionally, the operand size. The second channel also compares the data carried by the cycle against a target value with its own per-bit don't-care mask. The data lane is picked by the access size and the low address bits.

A mode bit selects how the channels combine. In independent mode a hit on either channel requests a break. In sequential mode a small state machine has two states. `SEQ_IDLE` moves to `SEQ_ARMED` on a channel A hit (transition ARM). `SEQ_ARMED` returns to `SEQ_IDLE` either when channel B hits in a later cycle, which raises the break (transition FIRE), or when the mode register is written (transition DISARM). A channel B hit in the same cycle as the arming A hit does not count.

The configuration is reached through a simple register port. The port accepts accesses only from the CPU master. Each channel has a sticky hit flag, and the break request is a registered one-cycle pulse.

Top module: `bus_break_unit`

## Requirements
- R1: A channel's address condition holds when every address bit not set in that channel's address mask equals the target address. Register word 0 holds the A target, word 1 the A mask, word 3 the B target and word 4 the B mask.
- R2: Address coverage depends on the access size. A byte access (size code 0) must hit the exact target. A word access (code 1) ignores address bit 0. A longword access (code 2) ignores address bits 1:0. So a longword at 0x...54 covers a target of 0x...56.
- R3: The qualifier field occupies bits 7:6 of the qualifier register (word 2 for A, word 7 for B). When this field is nonzero, the access size must equal the field value minus one. When the field is zero, any size is accepted.
- R4: Qualifier bits select the master and the kind of access. Bit 0 accepts CPU cycles and bit 1 accepts DMA cycles. Bit 2 accepts instruction fetches and bit 3 accepts data accesses. Bit 4 accepts reads and bit 5 accepts writes. A hit needs the accepting bit for each property of the cycle, and an idle bus never hits.
- R5: Channel B also compares data. For a byte access it uses lane `data[8*addr[1:0] +: 8]` against the low 8 bits of word 5. For a word access it uses `data[16*addr[1] +: 16]` against the low 16 bits. For a longword it uses all 32 bits. Bits set in word 6 are ignored.
- R6: In independent mode (word 8 bit 0 clear), a cycle that hits either channel raises `brk_irq` for exactly the next clock cycle.
- R7: In sequential mode (word 8 bit 0 set), `brk_irq` rises in the cycle after a channel B hit that comes strictly after an earlier channel A hit. A and B hitting in the same cycle from the idle state only arms the sequence. Each fire returns the sequence to idle.
- R8: Any write to the mode register discards a pending channel A hit.
- R9: Register accesses with `reg_dma` set are ignored. Writes change nothing, and reads return zero.
- R10: All registers reset to zero. Word 9 reads the sticky flags, with A in bit 0 and B in bit 1. A hit sets its flag. Writing word 9 clears each flag whose data bit is zero and keeps each flag whose data bit is one.
- R11: A DMA cycle is never an instruction fetch. A channel that accepts only DMA fetches never hits, and a DMA cycle flagged as a fetch is treated as a data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_data | input | 32 | Bus cycle data |
| bus_dma | input | 1 | Cycle mastered by DMA/peripheral (0 = CPU) |
| bus_ifetch | input | 1 | Cycle is an instruction fetch |
| bus_write | input | 1 | Cycle is a write (0 = read) |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| reg_en | input | 1 | Register port access strobe |
| reg_wr | input | 1 | Register port write (0 = read) |
| reg_dma | input | 1 | Register access comes from a non-CPU master |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| brk_irq | output | 1 | Break interrupt request pulse |

## Verification
The channel comparison is combinational. The break request is registered, so a bus cycle driven before edge N shows on `brk_irq` after edge N and is sampled at the following falling edge. Register writes take effect at the edge that captures them, while reads return data in the same cycle, so the bench samples read data shortly after it drives the read. The bench's reference model advances at each rising edge using the inputs held since the prior falling edge. It compares `brk_irq` at every falling edge, which keeps each expected value aligned to the one register between the bus and the output.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int REG_AW = 4;

    // register word indices
    localparam logic [REG_AW-1:0] IDX_A_ADDR = 4'd0;
    localparam logic [REG_AW-1:0] IDX_A_AMSK = 4'd1;
    localparam logic [REG_AW-1:0] IDX_A_QUAL = 4'd2;
    localparam logic [REG_AW-1:0] IDX_B_ADDR = 4'd3;
    localparam logic [REG_AW-1:0] IDX_B_AMSK = 4'd4;
    localparam logic [REG_AW-1:0] IDX_B_DATA = 4'd5;
    localparam logic [REG_AW-1:0] IDX_B_DMSK = 4'd6;
    localparam logic [REG_AW-1:0] IDX_B_QUAL = 4'd7;
    localparam logic [REG_AW-1:0] IDX_MODE   = 4'd8;
    localparam logic [REG_AW-1:0] IDX_FLAGS  = 4'd9;

    // bus access size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    // per-channel bus-cycle qualifier, msb first
    typedef struct packed {
        logic [1:0] size;   // 0 any, else bus size + 1
        logic       wr;
        logic       rd;
        logic       data;
        logic       fetch;
        logic       dma;
        logic       cpu;
    } qual_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

endpackage

// File: rtl/bbc_regs.sv
module bbc_regs
    import bbc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic              reg_dma,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              hit_a,
    input  logic              hit_b,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] a_addr,
    output logic [ADDR_W-1:0] a_amsk,
    output qual_t             a_qual,
    output logic [ADDR_W-1:0] b_addr,
    output logic [ADDR_W-1:0] b_amsk,
    output logic [DATA_W-1:0] b_data,
    output logic [DATA_W-1:0] b_dmsk,
    output qual_t             b_qual,
    output logic              seq_mode,
    output logic              mode_wr,
    output logic              flag_a,
    output logic              flag_b
);

    localparam int QUAL_W = $bits(qual_t);

    logic wr_ok;
    logic rd_ok;
    logic flag_wr;

    assign wr_ok   = reg_en & reg_wr & ~reg_dma;
    assign rd_ok   = reg_en & ~reg_wr & ~reg_dma;
    assign mode_wr = wr_ok && (reg_addr == IDX_MODE);
    assign flag_wr = wr_ok && (reg_addr == IDX_FLAGS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_addr   <= '0;
            a_amsk   <= '0;
            a_qual   <= '0;
            b_addr   <= '0;
            b_amsk   <= '0;
            b_data   <= '0;
            b_dmsk   <= '0;
            b_qual   <= '0;
            seq_mode <= 1'b0;
        end else if (wr_ok) begin
            case (reg_addr)
                IDX_A_ADDR: a_addr   <= reg_wdata[ADDR_W-1:0];
                IDX_A_AMSK: a_amsk   <= reg_wdata[ADDR_W-1:0];
                IDX_A_QUAL: a_qual   <= qual_t'(reg_wdata[QUAL_W-1:0]);
                IDX_B_ADDR: b_addr   <= reg_wdata[ADDR_W-1:0];
                IDX_B_AMSK: b_amsk   <= reg_wdata[ADDR_W-1:0];
                IDX_B_DATA: b_data   <= reg_wdata;
                IDX_B_DMSK: b_dmsk   <= reg_wdata;
                IDX_B_QUAL: b_qual   <= qual_t'(reg_wdata[QUAL_W-1:0]);
                IDX_MODE:   seq_mode <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // sticky hit flags: a hit wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            flag_a <= hit_a | (flag_a & ~(flag_wr & ~reg_wdata[0]));
            flag_b <= hit_b | (flag_b & ~(flag_wr & ~reg_wdata[1]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_ok) begin
            case (reg_addr)
                IDX_A_ADDR: reg_rdata = DATA_W'(a_addr);
                IDX_A_AMSK: reg_rdata = DATA_W'(a_amsk);
                IDX_A_QUAL: reg_rdata = DATA_W'(a_qual);
                IDX_B_ADDR: reg_rdata = DATA_W'(b_addr);
                IDX_B_AMSK: reg_rdata = DATA_W'(b_amsk);
                IDX_B_DATA: reg_rdata = b_data;
                IDX_B_DMSK: reg_rdata = b_dmsk;
                IDX_B_QUAL: reg_rdata = DATA_W'(b_qual);
                IDX_MODE:   reg_rdata = DATA_W'(seq_mode);
                IDX_FLAGS:  reg_rdata = DATA_W'({flag_b, flag_a});
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/bbc_chan.sv
module bbc_chan
    import bbc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_dma,
    input  logic              bus_ifetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [ADDR_W-1:0] tgt_amsk,
    input  qual_t             qual,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic [DATA_W-1:0] tgt_dmsk,
    output logic              hit
);

    logic [ADDR_W-1:0] low_ign;
    logic              addr_ok;
    logic              master_ok;
    logic              true_fetch;
    logic              kind_ok;
    logic              dir_ok;
    logic              size_ok;
    logic              data_ok;

    // address bits the access itself covers
    always_comb begin
        unique case (bus_size)
            SZ_LONG: low_ign = ADDR_W'(3);
            SZ_WORD: low_ign = ADDR_W'(1);
            default: low_ign = '0;
        endcase
    end

    assign addr_ok    = ((bus_addr ^ tgt_addr) & ~(tgt_amsk | low_ign)) == '0;
    assign master_ok  = bus_dma ? qual.dma : qual.cpu;
    assign true_fetch = bus_ifetch & ~bus_dma;
    assign kind_ok    = true_fetch ? qual.fetch : qual.data;
    assign dir_ok     = bus_write ? qual.wr : qual.rd;
    assign size_ok    = (qual.size == 2'd0) || (qual.size == (bus_size + 2'd1));

    generate
        if (HAS_DATA) begin : g_data
            logic [DATA_W-1:0] lane;
            logic [DATA_W-1:0] keep;

            always_comb begin
                unique case (bus_size)
                    SZ_BYTE: begin
                        lane = DATA_W'(bus_data[{bus_addr[1:0], 3'b000} +: BYTE_W]);
                        keep = DATA_W'({BYTE_W{1'b1}});
                    end
                    SZ_WORD: begin
                        lane = DATA_W'(bus_data[{bus_addr[1], 4'b0000} +: HALF_W]);
                        keep = DATA_W'({HALF_W{1'b1}});
                    end
                    default: begin
                        lane = bus_data;
                        keep = '1;
                    end
                endcase
            end

            assign data_ok = ((lane ^ tgt_data) & ~tgt_dmsk & keep) == '0;
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^{bus_data, tgt_data, tgt_dmsk};
            assign data_ok     = 1'b1;
        end
    endgenerate

    assign hit = bus_valid & addr_ok & master_ok & kind_ok & dir_ok & size_ok & data_ok;

endmodule

// File: rtl/bbc_seq.sv
module bbc_seq
    import bbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_mode,
    input  logic       mode_wr,
    input  logic       hit_a,
    input  logic       hit_b,
    output seq_state_e state,
    output logic       brk_irq
);

    seq_state_e state_nx;
    logic       fire;

    always_comb begin
        if (seq_mode)
            fire = (state == SEQ_ARMED) && hit_b;
        else
            fire = hit_a | hit_b;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: begin
                if (!mode_wr && seq_mode && hit_a)
                    state_nx = SEQ_ARMED;          // ARM
            end
            SEQ_ARMED: begin
                if (mode_wr)
                    state_nx = SEQ_IDLE;           // DISARM
                else if (hit_b)
                    state_nx = SEQ_IDLE;           // FIRE
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEQ_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_irq <= 1'b0;
        else
            brk_irq <= fire;
    end

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
    import bbc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_dma,
    input  logic              bus_ifetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic              reg_dma,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              brk_irq
);

    logic [ADDR_W-1:0] a_addr;
    logic [ADDR_W-1:0] a_amsk;
    qual_t             a_qual;
    logic [ADDR_W-1:0] b_addr;
    logic [ADDR_W-1:0] b_amsk;
    logic [DATA_W-1:0] b_data;
    logic [DATA_W-1:0] b_dmsk;
    qual_t             b_qual;
    logic              seq_mode;
    logic              mode_wr;
    logic              flag_a;
    logic              flag_b;
    logic              hit_a;
    logic              hit_b;
    seq_state_e        st;

    bbc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_wr    (reg_wr),
        .reg_dma   (reg_dma),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .reg_rdata (reg_rdata),
        .a_addr    (a_addr),
        .a_amsk    (a_amsk),
        .a_qual    (a_qual),
        .b_addr    (b_addr),
        .b_amsk    (b_amsk),
        .b_data    (b_data),
        .b_dmsk    (b_dmsk),
        .b_qual    (b_qual),
        .seq_mode  (seq_mode),
        .mode_wr   (mode_wr),
        .flag_a    (flag_a),
        .flag_b    (flag_b)
    );

    bbc_chan #(.ADDR_W(ADDR_W), .HAS_DATA(1'b0)) u_chan_a (
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_dma    (bus_dma),
        .bus_ifetch (bus_ifetch),
        .bus_write  (bus_write),
        .bus_size   (bus_size),
        .tgt_addr   (a_addr),
        .tgt_amsk   (a_amsk),
        .qual       (a_qual),
        .tgt_data   ('0),
        .tgt_dmsk   ('0),
        .hit        (hit_a)
    );

    bbc_chan #(.ADDR_W(ADDR_W), .HAS_DATA(1'b1)) u_chan_b (
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_dma    (bus_dma),
        .bus_ifetch (bus_ifetch),
        .bus_write  (bus_write),
        .bus_size   (bus_size),
        .tgt_addr   (b_addr),
        .tgt_amsk   (b_amsk),
        .qual       (b_qual),
        .tgt_data   (b_data),
        .tgt_dmsk   (b_dmsk),
        .hit        (hit_b)
    );

    bbc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_mode (seq_mode),
        .mode_wr  (mode_wr),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .state    (st),
        .brk_irq  (brk_irq)
    );

endmodule

// File: rtl/bbc_chk.sv
module bbc_chk
    import bbc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              brk_irq,
    input logic              hit_a,
    input logic              hit_b,
    input logic              seq_mode,
    input seq_state_e        st,
    input logic              reg_en,
    input logic              reg_wr,
    input logic              reg_dma,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [ADDR_W-1:0] a_addr,
    input logic              flag_a,
    input logic              flag_b
);

    logic prev_valid;
    logic prev_seq;
    logic prev_armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_seq   <= 1'b0;
            prev_armed <= 1'b0;
        end else begin
            prev_valid <= bus_valid;
            prev_seq   <= seq_mode;
            prev_armed <= (st == SEQ_ARMED);
        end
    end

    // R6
    irq_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> prev_valid);

    // R6
    indep_hit_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_mode && (hit_a || hit_b)) |=> brk_irq);

    // R7
    seq_fire_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_irq && prev_seq) |-> prev_armed);

    // R7
    seq_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && st == SEQ_IDLE && hit_a && hit_b) |=> !brk_irq);

    // R9
    dma_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_dma) |-> (reg_rdata == '0));

    // R9
    dma_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_wr && reg_dma) |=> $stable(a_addr));

    // R10
    flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flag_a);

    // R10
    flag_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> flag_b);

endmodule

bind bus_break_unit bbc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .brk_irq   (brk_irq),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .seq_mode  (seq_mode),
    .st        (st),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_dma   (reg_dma),
    .reg_rdata (reg_rdata),
    .a_addr    (a_addr),
    .flag_a    (flag_a),
    .flag_b    (flag_b)
);

// File: tb/bus_break_unit_bench.sv
module bus_break_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        bus_dma = 1'b0;
    logic        bus_ifetch = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_dma = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        brk_irq;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R10";
    string chk_req = "R10";

    // behavioural reference state
    bit [31:0] m_reg [10];
    bit        m_armed;
    bit        m_fa;
    bit        m_fb;
    bit        exp_irq;

    bus_break_unit u_bus_break_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_dma    (bus_dma),
        .bus_ifetch (bus_ifetch),
        .bus_write  (bus_write),
        .bus_size   (bus_size),
        .reg_en     (reg_en),
        .reg_wr     (reg_wr),
        .reg_dma    (reg_dma),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .brk_irq    (brk_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_hit(input int ch);
        bit [31:0] tgt, msk, lane, keep;
        bit [7:0]  q;
        int        shift_lo, shift_d;
        bit        fetch;
        tgt = (ch == 0) ? m_reg[0] : m_reg[3];
        msk = (ch == 0) ? m_reg[1] : m_reg[4];
        q   = (ch == 0) ? m_reg[2][7:0] : m_reg[7][7:0];
        if (!bus_valid) return 1'b0;
        if (bus_dma ? !q[1] : !q[0]) return 1'b0;
        fetch = bus_ifetch && !bus_dma;
        if (fetch ? !q[2] : !q[3]) return 1'b0;
        if (bus_write ? !q[5] : !q[4]) return 1'b0;
        if (q[7:6] != 0 && int'(q[7:6]) != int'(bus_size) + 1) return 1'b0;
        shift_lo = (bus_size == 2) ? 2 : (bus_size == 1) ? 1 : 0;
        if ((((bus_addr ^ tgt) & ~msk) >> shift_lo) != 0) return 1'b0;
        if (ch == 1) begin
            if (bus_size == 0) begin
                shift_d = 8 * int'(bus_addr % 4);
                keep = 32'hFF;
            end else if (bus_size == 1) begin
                shift_d = 16 * int'((bus_addr / 2) % 2);
                keep = 32'hFFFF;
            end else begin
                shift_d = 0;
                keep = 32'hFFFF_FFFF;
            end
            lane = (bus_data >> shift_d) & keep;
            if (((lane ^ m_reg[5]) & ~m_reg[6] & keep) != 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin : model
        bit ha, hb;
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = '0;
            m_armed = 0; m_fa = 0; m_fb = 0; exp_irq = 0;
        end else begin
            chk_req = cur_req;
            ha = m_hit(0);
            hb = m_hit(1);
            if (m_reg[8][0]) begin
                exp_irq = m_armed && hb;
                if (m_armed && hb) m_armed = 0;
                else if (!m_armed && ha) m_armed = 1;
            end else begin
                exp_irq = ha || hb;
            end
            if (reg_en && reg_wr && !reg_dma) begin
                if (reg_addr == 9) begin
                    if (!reg_wdata[0]) m_fa = 0;
                    if (!reg_wdata[1]) m_fb = 0;
                end else if (reg_addr < 9) begin
                    m_reg[reg_addr] = reg_wdata;
                end
                if (reg_addr == 8) m_armed = 0;
            end
            if (ha) m_fa = 1;
            if (hb) m_fb = 1;
        end
    end

    // break request compared against the model every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (brk_irq !== exp_irq) begin
                n_errors++;
                $display("FAIL %s brk_irq actual=%0b expected=%0b at %0t",
                         chk_req, brk_irq, exp_irq, $time);
            end
        end
    end

    task automatic bus(input string req, input logic [31:0] a, input logic [31:0] d,
                       input logic dma, input logic fe, input logic wr, input logic [1:0] sz);
        @(negedge clk);
        cur_req = req;
        reg_en = 0; reg_wr = 0; reg_dma = 0;
        bus_valid = 1; bus_addr = a; bus_data = d;
        bus_dma = dma; bus_ifetch = fe; bus_write = wr; bus_size = sz;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 0; reg_en = 0; reg_wr = 0; reg_dma = 0;
    endtask

    task automatic wreg(input int idx, input logic [31:0] v, input logic dma);
        @(negedge clk);
        bus_valid = 0;
        reg_en = 1; reg_wr = 1; reg_dma = dma; reg_addr = idx[3:0]; reg_wdata = v;
    endtask

    task automatic rreg(input string req, input int idx, input logic dma,
                        input logic [31:0] expv);
        @(negedge clk);
        bus_valid = 0;
        reg_en = 1; reg_wr = 0; reg_dma = dma; reg_addr = idx[3:0];
        #1;
        n_checks++;
        if (reg_rdata !== expv) begin
            n_errors++;
            $display("FAIL %s reg[%0d] actual=%h expected=%h", req, idx, reg_rdata, expv);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: reset state
        for (int i = 0; i < 10; i++) rreg("R10", i, 1'b0, 32'h0);

        // R1 R2 R4: channel A, CPU data read, any size
        wreg(0, 32'h0012_3456, 0);
        wreg(2, 32'h19, 0);
        rreg("R1", 0, 1'b0, 32'h0012_3456);
        bus("R2", 32'h0012_3454, 32'h0, 0, 0, 0, 2'd2);
        bus("R2", 32'h0012_3456, 32'h0, 0, 0, 0, 2'd1);
        bus("R2", 32'h0012_3456, 32'h0, 0, 0, 0, 2'd0);
        bus("R2", 32'h0012_3457, 32'h0, 0, 0, 0, 2'd0);
        bus("R2", 32'h0012_3454, 32'h0, 0, 0, 0, 2'd1);
        bus("R2", 32'h0012_3458, 32'h0, 0, 0, 0, 2'd2);
        bus("R4", 32'h0012_3456, 32'h0, 0, 0, 1, 2'd1);
        bus("R4", 32'h0012_3456, 32'h0, 0, 1, 0, 2'd1);
        bus("R4", 32'h0012_3456, 32'h0, 1, 0, 0, 2'd1);
        idle();
        bus("R4", 32'h0012_3456, 32'h0, 0, 0, 0, 2'd1);
        bus("R6", 32'h0012_3456, 32'h0, 0, 0, 0, 2'd1);
        idle();
        wreg(1, 32'h0000_00F0, 0);
        bus("R1", 32'h0012_3406, 32'h0, 0, 0, 0, 2'd0);
        bus("R1", 32'h0012_3416, 32'h0, 0, 0, 0, 2'd0);
        bus("R1", 32'h0012_3506, 32'h0, 0, 0, 0, 2'd0);
        idle();

        // R3 R5: channel B, CPU word write with data
        wreg(2, 32'h0, 0);
        wreg(3, 32'h000A_BCDE, 0);
        wreg(4, 32'h0000_00FF, 0);
        wreg(5, 32'h0000_A512, 0);
        wreg(7, 32'hA9, 0);
        bus("R5", 32'h000A_BC00, 32'h0000_A512, 0, 0, 1, 2'd1);
        bus("R5", 32'h000A_BCFE, 32'hA512_0000, 0, 0, 1, 2'd1);
        bus("R5", 32'h000A_BCFE, 32'h0000_A512, 0, 0, 1, 2'd1);
        bus("R5", 32'h000A_BC00, 32'h0000_A513, 0, 0, 1, 2'd1);
        bus("R3", 32'h000A_BC00, 32'h0000_0012, 0, 0, 1, 2'd0);
        bus("R3", 32'h000A_BC00, 32'h0000_A512, 0, 0, 1, 2'd2);
        bus("R1", 32'h000A_BD00, 32'h0000_A512, 0, 0, 1, 2'd1);
        idle();

        // R11 R5: DMA cycles, fetch never seen, byte lane with masked nibble
        wreg(0, 32'h0031_4156, 0);
        wreg(1, 32'h0, 0);
        wreg(2, 32'h16, 0);
        wreg(3, 32'h0005_5555, 0);
        wreg(4, 32'h0, 0);
        wreg(5, 32'h0000_7878, 0);
        wreg(6, 32'h0000_0F0F, 0);
        wreg(7, 32'h6A, 0);
        bus("R11", 32'h0031_4156, 32'h0, 1, 1, 0, 2'd2);
        bus("R11", 32'h0031_4156, 32'h0, 1, 0, 0, 2'd2);
        bus("R5", 32'h0005_5555, 32'h0000_7300, 1, 0, 1, 2'd0);
        bus("R5", 32'h0005_5555, 32'h0000_6300, 1, 0, 1, 2'd0);
        bus("R4", 32'h0005_5555, 32'h0000_7300, 0, 0, 1, 2'd0);
        bus("R5", 32'h0005_5554, 32'h0000_0073, 1, 0, 1, 2'd0);
        idle();

        // R7 R8: sequential mode
        wreg(0, 32'h100, 0);
        wreg(2, 32'h19, 0);
        wreg(3, 32'h200, 0);
        wreg(4, 32'h300, 0);
        wreg(6, 32'hFFFF_FFFF, 0);
        wreg(7, 32'h19, 0);
        wreg(8, 32'h1, 0);
        rreg("R7", 8, 1'b0, 32'h1);
        bus("R7", 32'h200, 32'h0, 0, 0, 0, 2'd2);
        bus("R7", 32'h000, 32'h0, 0, 0, 0, 2'd2);
        bus("R7", 32'h100, 32'h0, 0, 0, 0, 2'd2);
        idle();
        bus("R7", 32'h200, 32'h0, 0, 0, 0, 2'd2);
        bus("R7", 32'h200, 32'h0, 0, 0, 0, 2'd2);
        bus("R7", 32'h100, 32'h0, 0, 0, 0, 2'd2);
        bus("R7", 32'h100, 32'h0, 0, 0, 0, 2'd2);
        bus("R7", 32'h300, 32'h0, 0, 0, 0, 2'd2);
        idle();
        bus("R8", 32'h100, 32'h0, 0, 0, 0, 2'd2);
        wreg(8, 32'h1, 0);
        bus("R8", 32'h200, 32'h0, 0, 0, 0, 2'd2);
        idle();
        wreg(8, 32'h0, 0);
        bus("R6", 32'h100, 32'h0, 0, 0, 0, 2'd2);
        idle();

        // R9: non-CPU register accesses
        wreg(0, 32'hDEAD_BEEF, 1);
        wreg(8, 32'h1, 1);
        rreg("R9", 0, 1'b0, 32'h100);
        rreg("R9", 8, 1'b0, 32'h0);
        rreg("R9", 0, 1'b1, 32'h0);

        // R10: sticky flags and clear by zero
        rreg("R10", 9, 1'b0, 32'h3);
        wreg(9, 32'h2, 0);
        rreg("R10", 9, 1'b0, 32'h2);
        wreg(9, 32'h0, 0);
        rreg("R10", 9, 1'b0, 32'h0);
        rreg("R10", 2, 1'b0, 32'h19);

        repeat (3) idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule